// File: doc/BRIEF.md
# SPI Flash Interface Rescue Sequencer

At power-up a serial flash may still be in a dual-line, quad-line or double-data-rate state left over from earlier use. In that state it does not recognise plain single-line commands. This block runs once, on a start strobe, before any boot read. It forces the flash back into single-line SPI, issues the two-step software reset, waits for the flash to recover, and then opens a single-line read at address zero.

Each pass sends six chip-select frames:

1. Three mode-exit bursts of 2, 8 and 16 serial clocks. During these, DQ0, DQ2 and DQ3 are held at logic 1. Because the lines stay constant for the whole frame, a flash in double-data-rate mode also sees 1 on both clock edges.
2. The reset-enable opcode 0x66.
3. The reset opcode 0x99.
4. After a programmable recovery wait, the read opcode 0x03 followed by a 24-bit zero address.

Chip select stays low after the read frame, so a downstream reader can clock in data directly. A one-cycle done pulse marks that point. The serial clock is derived from the system clock through a divider input and idles low (SPI mode 0).

Top module: `flash_rescue_seq`

## Requirements
- R1: While reset is applied, and afterwards until start is seen, the outputs are `cs_n`=1, `sck`=0, `dq_oe`=0 and `done`=0.
- R2: A start seen while idle produces exactly six chip-select-low frames. Their `sck` rising-edge counts are, in order, 2, 8, 16, 8, 8 and 32.
- R3: In the first three frames, DQ0, DQ2 and DQ3 are 1 at every `sck` rising edge.
- R4: Frames four to six carry 0x66, 0x99 and then 0x03 followed by 24 zero bits, MSB first on DQ0. While a frame is open, `dq_oe` is 4'b1101: DQ1 is never driven, and DQ2 and DQ3 are driven high.
- R5: `sck` is 0 whenever `cs_n` is 1. `cs_n` rises on the same edge as the final `sck` fall of a frame, before any further rising edge.
- R6: Between consecutive frames, `cs_n` stays high for at least GAP_CYC system clocks.
- R7: Between the reset frame and the read frame, `cs_n` stays high for at least WAIT_CYC system clocks.
- R8: Each `sck` high phase and low phase lasts `div`+1 system clocks, so `div`=0 gives half the system clock rate.
- R9: `done` is high for exactly one cycle, on the edge where the last address bit's clock falls. After that, `cs_n` stays 0 and `sck` stays 0.
- R10: A start strobe during a sequence is ignored, and the frame list is unchanged.
- R11: A start after `done` raises `cs_n` and repeats the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a rescue pass (taken only while idle) |
| div | input | DIVW | Serial clock half-period minus one, in system clocks |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| dq_out | output | 4 | Values for DQ3..DQ0 |
| dq_oe | output | 4 | Output enables for DQ3..DQ0 |
| done | output | 1 | One-cycle pulse when the read header has been sent |

## Verification
The assertions assume that `div` does not change while a frame is shifting. They also assume that `start` matters only when the block is idle. The bench changes `div` only between passes, once `done` has been seen. It pulses `start` in the middle of a pass only to show that the strobe is ignored. With those inputs, every frame boundary lands on a full serial clock, so the per-edge checks on the chip select and the data lines apply to every cycle.

// File: rtl/flash_rescue_pkg.sv
package flash_rescue_pkg;
  localparam int NUM_FRAMES  = 6;
  localparam int IDX_W       = 3;
  localparam int LEN_W       = 6;
  localparam int WORD_W      = 32;
  localparam int EXIT_FRAMES = 3;
  localparam int RESET_FRAME = 4;
  localparam int READ_FRAME  = 5;

  localparam logic [7:0] OP_RST_ENABLE = 8'h66;
  localparam logic [7:0] OP_RST_DO     = 8'h99;
  localparam logic [7:0] OP_READ_1X    = 8'h03;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_GAP, SEQ_SHIFT} seq_state_t;

  // number of serial clocks in each frame
  function automatic logic [LEN_W-1:0] frame_len(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    frame_len = LEN_W'(2);
      3'd1:    frame_len = LEN_W'(8);
      3'd2:    frame_len = LEN_W'(16);
      3'd5:    frame_len = LEN_W'(32);
      default: frame_len = LEN_W'(8);
    endcase
  endfunction

  // left-aligned bit pattern of each frame
  function automatic logic [WORD_W-1:0] frame_word(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd3:    frame_word = {OP_RST_ENABLE, 24'h0};
      3'd4:    frame_word = {OP_RST_DO, 24'h0};
      3'd5:    frame_word = {OP_READ_1X, 24'h0};
      default: frame_word = ~({WORD_W{1'b1}} >> frame_len(idx));
    endcase
  endfunction
endpackage

// File: rtl/rescue_sck_gen.sv
module rescue_sck_gen #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sck,
  output logic            bit_end
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            sck_q, sck_d;
  logic            term;

  assign term    = (cnt_q == div);
  assign bit_end = run && term && sck_q;
  assign sck     = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
  assert_div_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (!run || $stable(div)));
endmodule

// File: rtl/rescue_shifter.sv
module rescue_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q, sr_d;

  assign msb = sr_q[W-1];

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_word;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/rescue_timer.sv
module rescue_timer #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (!expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_rescue_seq.sv
module flash_rescue_seq
  import flash_rescue_pkg::*;
#(
  parameter int DIVW     = 4,
  parameter int GAP_CYC  = 4,
  parameter int WAIT_CYC = 6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIVW-1:0] div,
  output logic            cs_n,
  output logic            sck,
  output logic [3:0]      dq_out,
  output logic [3:0]      dq_oe,
  output logic            done
);
  localparam int HOLD_MAX = (WAIT_CYC > GAP_CYC) ? WAIT_CYC : GAP_CYC;
  localparam int TW       = $clog2(HOLD_MAX + 1);
  localparam logic [TW-1:0] GAP_LOAD  = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(WAIT_CYC - 1);
  localparam logic [3:0] DRIVE_MASK   = 4'b1101;

  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_nxt;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              cs_q, cs_d;
  logic              done_q, done_d;

  logic              run, bit_end, sh_msb, expired;
  logic              tmr_load, sh_load, sh_shift;
  logic [TW-1:0]     tmr_val;
  logic [WORD_W-1:0] sh_word;
  logic              active;

  assign idx_nxt = IDX_W'(idx_q + 1'b1);
  assign run     = (state_q == SEQ_SHIFT);

  rescue_sck_gen #(.DIVW(DIVW)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .sck(sck), .bit_end(bit_end)
  );

  rescue_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_word(sh_word),
    .shift(sh_shift), .msb(sh_msb)
  );

  rescue_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    left_d   = left_q;
    cs_d     = cs_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = GAP_LOAD;
    sh_load  = 1'b0;
    sh_word  = frame_word(idx_nxt);
    sh_shift = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d  = SEQ_GAP;
          idx_d    = '0;
          left_d   = frame_len('0);
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          sh_load  = 1'b1;
          sh_word  = frame_word('0);
        end
      end
      SEQ_GAP: begin
        if (expired) begin
          state_d = SEQ_SHIFT;
          cs_d    = 1'b0;
        end
      end
      default: begin
        if (bit_end) begin
          if (left_q == LEN_W'(1)) begin
            if (idx_q == IDX_W'(READ_FRAME)) begin
              state_d = SEQ_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d  = SEQ_GAP;
              idx_d    = idx_nxt;
              left_d   = frame_len(idx_nxt);
              cs_d     = 1'b1;
              tmr_load = 1'b1;
              tmr_val  = (idx_q == IDX_W'(RESET_FRAME)) ? WAIT_LOAD : GAP_LOAD;
              sh_load  = 1'b1;
            end
          end else begin
            left_d   = left_q - LEN_W'(1);
            sh_shift = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      left_q  <= left_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
    end
  end

  assign active = (state_q != SEQ_IDLE) || !cs_q;
  assign cs_n   = cs_q;
  assign done   = done_q;
  assign dq_oe  = active ? DRIVE_MASK : 4'b0000;
  assign dq_out = active ? {1'b1, 1'b1, 1'b0, sh_msb} : 4'b0000;

  assert_sck_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_hold_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (dq_oe == DRIVE_MASK) && dq_out[3] && dq_out[2]);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs_n && !sck);
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE) && start |=> idx_q >= $past(idx_q));
endmodule

// File: tb/flash_rescue_seq_test.sv
`timescale 1ns/1ps
module flash_rescue_seq_test;
  localparam int DIVW = 4, GAP_CYC = 4, WAIT_CYC = 6000, NF = 6;
  // frame rising-edge count and left-aligned expected bits
  localparam logic [37:0] EXP [NF] = '{
    {6'd2,  32'hC000_0000}, {6'd8,  32'hFF00_0000}, {6'd16, 32'hFFFF_0000},
    {6'd8,  32'h6600_0000}, {6'd8,  32'h9900_0000}, {6'd32, 32'h0300_0000}};

  logic clk = 1'b0;
  logic rst_n, start;
  logic [DIVW-1:0] div;
  logic cs_n, sck, done;
  logic [3:0] dq_out, dq_oe;

  always #2.5 clk = ~clk;

  flash_rescue_seq #(.DIVW(DIVW), .GAP_CYC(GAP_CYC), .WAIT_CYC(WAIT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .div(div), .cs_n(cs_n), .sck(sck),
    .dq_out(dq_out), .dq_oe(dq_oe), .done(done));

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor
  logic mon_clr = 1'b1;
  int   cur_div = 0;
  logic prev_sck, prev_cs, prev_done;
  int   bitcnt, nframes, gapcnt, gap_min, gap_wait, hi_cnt, done_cnt;
  int   bad_exit, bad_oe, bad_hi, bad_sck, bad_done;
  logic [31:0] shreg;
  int   got_len [NF];
  logic [31:0] got_word [NF];

  task automatic close_frame();
    if (nframes < NF) begin
      got_len[nframes]  = bitcnt;
      got_word[nframes] = (bitcnt > 0 && bitcnt <= 32) ? (shreg << (32 - bitcnt)) : shreg;
    end
    nframes++;
    bitcnt = 0;
    shreg  = '0;
  endtask

  always @(negedge clk) begin
    if (mon_clr) begin
      bitcnt = 0; nframes = 0; gapcnt = 0; gap_min = 1000000; gap_wait = 0;
      hi_cnt = 0; done_cnt = 0; shreg = '0;
      bad_exit = 0; bad_oe = 0; bad_hi = 0; bad_sck = 0; bad_done = 0;
    end else begin
      if (sck) hi_cnt++;
      if (sck && !prev_sck && !cs_n) begin
        bitcnt++;
        shreg = {shreg[30:0], dq_out[0]};
        if (nframes < 3 && !(dq_out[0] && dq_out[2] && dq_out[3])) bad_exit++;
        if (dq_oe != 4'b1101) bad_oe++;
      end
      if (!sck && prev_sck) begin
        if (hi_cnt != cur_div + 1) bad_hi++;
        hi_cnt = 0;
      end
      if (cs_n && !prev_cs && bitcnt > 0) close_frame();
      if (cs_n && !prev_cs) gapcnt = 0;
      if (cs_n) gapcnt++;
      if (!cs_n && prev_cs) begin
        if (nframes == 5) gap_wait = gapcnt;
        else if (nframes > 0 && gapcnt < gap_min) gap_min = gapcnt;
      end
      if (done) begin
        close_frame();
        done_cnt++;
        if (cs_n || sck) bad_done++;
        if (prev_done) bad_done++;
      end
      if (sck && cs_n) bad_sck++;
    end
    prev_sck  = sck;
    prev_cs   = cs_n;
    prev_done = done;
  end

  task automatic run_seq(input int d, input bit poke, input string tag);
    bit poked = 0;
    int t = 0;
    @(negedge clk); #1 div = DIVW'(d); cur_div = d; mon_clr = 1'b1;
    @(negedge clk); #1 mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    while (done_cnt == 0 && t < 100000) begin
      @(negedge clk);
      t++;
      if (poke && !poked && nframes == 2) begin
        #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        poked = 1;
      end
    end
    check(done_cnt != 0, {tag, " watchdog R9"}, 64'(t), 64'(100000));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && done_cnt == 1, {tag, " R9 done single pulse"}, 64'(done_cnt), 64'd1);
    check(cs_n == 1'b0 && sck == 1'b0, {tag, " R9 parked cs_n/sck"}, {62'd0, cs_n, sck}, 64'd0);
    check(nframes == NF, {tag, " R2 R10 frame count"}, 64'(nframes), 64'(NF));
    for (int i = 0; i < NF; i++) begin
      check(got_len[i] == int'(EXP[i][37:32]), {tag, " R2 frame length"}, 64'(got_len[i]), 64'(EXP[i][37:32]));
      check(got_word[i] == EXP[i][31:0], {tag, (i < 3) ? " R3 exit bits" : " R4 command bits"},
            64'(got_word[i]), 64'(EXP[i][31:0]));
    end
    check(bad_exit == 0, {tag, " R3 lines high"}, 64'(bad_exit), 64'd0);
    check(bad_oe == 0, {tag, " R4 enables"}, 64'(bad_oe), 64'd0);
    check(bad_sck == 0, {tag, " R5 sck with cs high"}, 64'(bad_sck), 64'd0);
    check(gap_min >= GAP_CYC, {tag, " R6 frame gap"}, 64'(gap_min), 64'(GAP_CYC));
    check(gap_wait >= WAIT_CYC, {tag, " R7 reset wait"}, 64'(gap_wait), 64'(WAIT_CYC));
    check(bad_hi == 0, {tag, " R8 sck high phase"}, 64'(bad_hi), 64'd0);
    check(bad_done == 0, {tag, " R9 done shape"}, 64'(bad_done), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; div = '0;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 reset cs_n/sck", {62'd0, cs_n, sck}, 64'h2);
    check(dq_oe == 4'b0 && done == 1'b0, "R1 reset oe/done", {59'd0, dq_oe, done}, 64'd0);
    #1 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(cs_n == 1'b1 && dq_oe == 4'b0, "R1 idle without start", {59'd0, cs_n, dq_oe}, 64'h10);
    run_seq(0, 1'b0, "div0");
    run_seq(2, 1'b1, "div2 R10 R11");
    run_seq(1, 1'b0, "div1 R11");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule